// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Bank

This block is a bank of lock semaphores through which several bus masters share resources safely. Every semaphore keeps a lock flag, the core ID of its owner and a process ID. A master can claim a semaphore in two ways. It can write a claim and then read the register back to see whether it won. Or it can read an alias address that claims a free semaphore and returns the result in the same access. A semaphore is freed by a release write that must carry the owner's core ID and process ID. A keyed bulk-release write frees every semaphore held by one core in a single cycle.

Each core index has its own interrupt enable, status and clear registers. A release raises a status bit for each core that has enabled that semaphore. The bank has several request ports, one per master, all sampled in the same cycle. The ports act on the semaphores in a fixed order, lowest port first. Every semaphore is a two-state machine. Its states are `SEM_FREE` and `SEM_HELD`. Three transitions connect them. TAKE goes from free to held, on a valid claim write or an alias read. RELEASE goes from held to free, on a matching release write. FLUSH goes from held to free, on a bulk release with the correct key for the owning core. Every other access leaves the state unchanged.

The decoder sorts each port access into one kind: semaphore read, semaphore write, alias read, bulk write, key write, key read, enable write, enable read, status read, clear write, masked-status read, or other read.

Top module: `hsem_bank`

## Requirements
- R1: After reset every semaphore reads as zero (free, core ID 0, process ID 0). All enable and status registers are zero, every `irq_out` bit is low, and the clear key is 0.
- R2: A semaphore word has the lock flag in bit 31, the core ID in bits 11:8 and the process ID in bits 7:0. Writing lock=1 with a core ID equal to the port's `req_mid` to the address of a free semaphore (0 to N_SEM-1) takes it with the written core ID and process ID. A read of that address returns the stored fields.
- R3: A read of alias address N_SEM+i takes semaphore i if it is free. The new owner is the requesting `req_mid` with process ID 0, and the read returns lock=1, that core ID and process ID 0.
- R4: A claim write or an alias read aimed at a semaphore that is already held leaves it unchanged. An alias read in that case returns the current owner's fields.
- R5: A claim write whose core ID differs from the port's `req_mid` is ignored.
- R6: A write with lock=0 frees a held semaphore only when the written core ID equals both `req_mid` and the owner's core ID and the written process ID equals the owner's. Any other release write has no effect. Freeing clears both ID fields.
- R7: The clear key is written and read at address 2*N_SEM+1, in bits 15:0. A write to address 2*N_SEM carries a key in bits 31:16 and a core ID in bits 11:8. When the key equals the stored clear key, every semaphore held by that core ID is freed in that cycle. Otherwise nothing changes.
- R8: The registers for core index c start at 2*N_SEM+4+4c: enable at +0, status at +1, clear at +2, and masked status at +3. Every release (single or bulk) sets status bit i of each core whose enable bit i was set before that cycle. `irq_out[c]` is the OR of core c's status bits ANDed with its enable bits.
- R9: Writing 1 to a bit of a core's clear register clears the matching status bit. Writing 0 leaves it.
- R10: Requests that arrive in the same cycle are applied in port order, lowest index first. Each later port sees the result of the earlier ones. When two ports alias-read one free semaphore, port 0 takes it and both reads return port 0's ownership. A release from a lower port lets a higher port take the same semaphore in the same cycle.
- R11: When a release and a clear of the same status bit fall in the same cycle, the status bit ends up set.
- R12: Each read produces `rsp_valid` for exactly one cycle, on the cycle after the request. `rsp_rdata` holds the register value after that request cycle's updates. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Request valid, one per port |
| req_write | input | N_PORTS | 1 = write, 0 = read, one per port |
| req_addr | input | N_PORTS x 8 | Word address per port |
| req_wdata | input | N_PORTS x 32 | Write data per port |
| req_mid | input | N_PORTS x 4 | Bus master core ID carried by each request |
| rsp_valid | output | N_PORTS | Read response valid, one cycle after a read |
| rsp_rdata | output | N_PORTS x 32 | Read response data |
| irq_out | output | N_CORES | Release interrupt per core index |

## Verification
The bench drives both ports in the same cycle to create overlapping functions. First, two masters alias-read the same free semaphore together; the bench expects both responses to show port 0 as owner. Second, port 0 releases a semaphore while port 1 takes it; the bench expects the alias read on port 1 to win the lock. Third, a release falls in the same cycle as a clear of the status bit it raises; the bench judges this by reading the status and masked-status registers afterwards and by sampling the interrupt line.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int CORE_W   = 4;
    localparam int PROC_W   = 8;
    localparam int KEY_W    = 16;
    localparam int LOCK_BIT = 31;
    localparam int CORE_LSB = 8;
    localparam int KEY_LSB  = 16;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_SEM_RD,
        ACC_SEM_WR,
        ACC_ALIAS_RD,
        ACC_BULK_WR,
        ACC_KEY_WR,
        ACC_KEY_RD,
        ACC_IER_WR,
        ACC_IER_RD,
        ACC_ISR_RD,
        ACC_ICR_WR,
        ACC_MIS_RD,
        ACC_OTHER_RD
    } acc_kind_e;

    typedef enum logic {
        SEM_FREE,
        SEM_HELD
    } sem_state_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [ADDR_W-1:0]  idx;   // semaphore index or core index
        logic [CORE_W-1:0]  mid;   // requesting master ID
        logic               hit;   // bulk key matches the stored clear key
        logic [DATA_W-1:0]  data;
    } hsem_req_t;

endpackage

// File: rtl/hsem_port_decode.sv
module hsem_port_decode
    import hsem_pkg::*;
#(
    parameter int N_SEM   = 32,
    parameter int N_CORES = 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CORE_W-1:0] req_mid,
    input  logic [KEY_W-1:0]  clear_key,
    output hsem_req_t         req
);

    localparam logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'(N_SEM);
    localparam logic [ADDR_W-1:0] BULK_ADDR  = ADDR_W'(2 * N_SEM);
    localparam logic [ADDR_W-1:0] KEY_ADDR   = ADDR_W'(2 * N_SEM + 1);
    localparam logic [ADDR_W-1:0] IRQ_BASE   = ADDR_W'(2 * N_SEM + 4);
    localparam logic [ADDR_W-1:0] IRQ_END    = ADDR_W'(2 * N_SEM + 4 + 4 * N_CORES);

    logic [ADDR_W-1:0] irq_off;

    assign irq_off = req_addr - IRQ_BASE;

    always_comb begin
        req.kind = ACC_NONE;
        req.idx  = '0;
        req.mid  = req_mid;
        req.data = req_wdata;
        req.hit  = (req_wdata[KEY_LSB +: KEY_W] == clear_key);
        if (req_valid) begin
            if (req_addr < ALIAS_BASE) begin
                req.kind = req_write ? ACC_SEM_WR : ACC_SEM_RD;
                req.idx  = req_addr;
            end else if (req_addr < BULK_ADDR) begin
                req.kind = req_write ? ACC_NONE : ACC_ALIAS_RD;
                req.idx  = req_addr - ALIAS_BASE;
            end else if (req_addr == BULK_ADDR) begin
                req.kind = req_write ? ACC_BULK_WR : ACC_OTHER_RD;
            end else if (req_addr == KEY_ADDR) begin
                req.kind = req_write ? ACC_KEY_WR : ACC_KEY_RD;
            end else if (req_addr >= IRQ_BASE && req_addr < IRQ_END) begin
                req.idx = {2'b00, irq_off[ADDR_W-1:2]};
                unique case (irq_off[1:0])
                    2'd0: req.kind = req_write ? ACC_IER_WR : ACC_IER_RD;
                    2'd1: req.kind = req_write ? ACC_NONE   : ACC_ISR_RD;
                    2'd2: req.kind = req_write ? ACC_ICR_WR : ACC_OTHER_RD;
                    2'd3: req.kind = req_write ? ACC_NONE   : ACC_MIS_RD;
                endcase
            end else begin
                req.kind = req_write ? ACC_NONE : ACC_OTHER_RD;
            end
        end
    end

endmodule

// File: rtl/hsem_cell.sv
module hsem_cell
    import hsem_pkg::*;
#(
    parameter int N_PORTS = 2,
    parameter int SEM_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hsem_req_t         req [N_PORTS],
    output logic              held,
    output logic              released,
    output logic [DATA_W-1:0] nxt_word
);

    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(SEM_IDX);

    sem_state_e        st_q, st_n;
    logic [CORE_W-1:0] core_q, core_n;
    logic [PROC_W-1:0] proc_q, proc_n;
    logic              rel;
    logic [N_PORTS-1:0] unused_data;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_sink
        assign unused_data[p] = ^req[p].data;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEM_FREE;
            core_q <= '0;
            proc_q <= '0;
        end else begin
            st_q   <= st_n;
            core_q <= core_n;
            proc_q <= proc_n;
        end
    end

    // transitions, applied port by port in priority order
    always_comb begin
        st_n   = st_q;
        core_n = core_q;
        proc_n = proc_q;
        rel    = 1'b0;
        for (int p = 0; p < N_PORTS; p++) begin
            unique case (req[p].kind)
                ACC_SEM_WR: begin
                    if (req[p].idx == IDX) begin
                        if (req[p].data[LOCK_BIT]) begin
                            if (st_n == SEM_FREE &&
                                req[p].data[CORE_LSB +: CORE_W] == req[p].mid) begin
                                st_n   = SEM_HELD;
                                core_n = req[p].data[CORE_LSB +: CORE_W];
                                proc_n = req[p].data[PROC_W-1:0];
                            end
                        end else if (st_n == SEM_HELD &&
                                     req[p].data[CORE_LSB +: CORE_W] == req[p].mid &&
                                     req[p].data[CORE_LSB +: CORE_W] == core_n &&
                                     req[p].data[PROC_W-1:0] == proc_n) begin
                            st_n   = SEM_FREE;
                            core_n = '0;
                            proc_n = '0;
                            rel    = 1'b1;
                        end
                    end
                end
                ACC_ALIAS_RD: begin
                    if (req[p].idx == IDX && st_n == SEM_FREE) begin
                        st_n   = SEM_HELD;
                        core_n = req[p].mid;
                        proc_n = '0;
                    end
                end
                ACC_BULK_WR: begin
                    if (req[p].hit && st_n == SEM_HELD &&
                        core_n == req[p].data[CORE_LSB +: CORE_W]) begin
                        st_n   = SEM_FREE;
                        core_n = '0;
                        proc_n = '0;
                        rel    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        nxt_word                       = '0;
        nxt_word[LOCK_BIT]             = (st_n == SEM_HELD);
        nxt_word[CORE_LSB +: CORE_W]   = core_n;
        nxt_word[PROC_W-1:0]           = proc_n;
        held                           = (st_q == SEM_HELD);
        released                       = rel;
    end

endmodule

// File: rtl/hsem_irq_core.sv
module hsem_irq_core
    import hsem_pkg::*;
#(
    parameter int N_SEM    = 32,
    parameter int N_PORTS  = 2,
    parameter int CORE_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hsem_req_t        req [N_PORTS],
    input  logic [N_SEM-1:0] rel_vec,
    output logic [N_SEM-1:0] ier_q,
    output logic [N_SEM-1:0] isr_q,
    output logic             irq
);

    localparam logic [ADDR_W-1:0] CIDX = ADDR_W'(CORE_IDX);

    logic [N_SEM-1:0]   ier_n, isr_n, clr;
    logic [N_PORTS-1:0] unused_fields;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_sink
        assign unused_fields[p] = ^{req[p].mid, req[p].hit, req[p].data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q <= '0;
            isr_q <= '0;
        end else begin
            ier_q <= ier_n;
            isr_q <= isr_n;
        end
    end

    always_comb begin
        ier_n = ier_q;
        clr   = '0;
        for (int p = N_PORTS - 1; p >= 0; p--) begin
            if (req[p].idx == CIDX) begin
                if (req[p].kind == ACC_IER_WR) ier_n = req[p].data[N_SEM-1:0];
                if (req[p].kind == ACC_ICR_WR) clr   = clr | req[p].data[N_SEM-1:0];
            end
        end
        // a release in the same cycle wins over a clear
        isr_n = (isr_q & ~clr) | (rel_vec & ier_q);
        irq   = |(isr_q & ier_q);
    end

endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int N_SEM   = 32,
    parameter int N_CORES = 2,
    parameter int N_PORTS = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_PORTS-1:0]              req_valid,
    input  logic [N_PORTS-1:0]              req_write,
    input  logic [N_PORTS-1:0][ADDR_W-1:0]  req_addr,
    input  logic [N_PORTS-1:0][DATA_W-1:0]  req_wdata,
    input  logic [N_PORTS-1:0][CORE_W-1:0]  req_mid,
    output logic [N_PORTS-1:0]              rsp_valid,
    output logic [N_PORTS-1:0][DATA_W-1:0]  rsp_rdata,
    output logic [N_CORES-1:0]              irq_out
);

    localparam int SIDX_W = (N_SEM > 1) ? $clog2(N_SEM) : 1;
    localparam int CIDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

    hsem_req_t                    req [N_PORTS];
    logic [KEY_W-1:0]             key_q;
    logic [N_SEM-1:0]             held_vec, rel_vec;
    logic [DATA_W-1:0]            sem_word [N_SEM];
    logic [N_CORES-1:0][N_SEM-1:0] ier_all, isr_all;
    logic [DATA_W-1:0]            rd_word [N_PORTS];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic [DATA_W-1:0] rd_mux;

        hsem_port_decode #(.N_SEM(N_SEM), .N_CORES(N_CORES)) u_dec (
            .req_valid (req_valid[p]),
            .req_write (req_write[p]),
            .req_addr  (req_addr[p]),
            .req_wdata (req_wdata[p]),
            .req_mid   (req_mid[p]),
            .clear_key (key_q),
            .req       (req[p])
        );

        always_comb begin
            rd_mux = '0;
            unique case (req[p].kind)
                ACC_SEM_RD, ACC_ALIAS_RD: rd_mux = sem_word[req[p].idx[SIDX_W-1:0]];
                ACC_KEY_RD: rd_mux = DATA_W'(key_q);
                ACC_IER_RD: rd_mux = DATA_W'(ier_all[req[p].idx[CIDX_W-1:0]]);
                ACC_ISR_RD: rd_mux = DATA_W'(isr_all[req[p].idx[CIDX_W-1:0]]);
                ACC_MIS_RD: rd_mux = DATA_W'(isr_all[req[p].idx[CIDX_W-1:0]] &
                                             ier_all[req[p].idx[CIDX_W-1:0]]);
                default: ;
            endcase
        end

        assign rd_word[p] = rd_mux;
    end

    for (genvar s = 0; s < N_SEM; s++) begin : g_sem
        hsem_cell #(.N_PORTS(N_PORTS), .SEM_IDX(s)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req),
            .held     (held_vec[s]),
            .released (rel_vec[s]),
            .nxt_word (sem_word[s])
        );
    end

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        hsem_irq_core #(.N_SEM(N_SEM), .N_PORTS(N_PORTS), .CORE_IDX(c)) u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req),
            .rel_vec (rel_vec),
            .ier_q   (ier_all[c]),
            .isr_q   (isr_all[c]),
            .irq     (irq_out[c])
        );
    end

    // clear key: lowest port wins on simultaneous writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else begin
            for (int p = N_PORTS - 1; p >= 0; p--) begin
                if (req[p].kind == ACC_KEY_WR) key_q <= req_wdata[p][KEY_W-1:0];
            end
        end
    end

    // read responses, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_rdata <= '0;
        end else begin
            for (int p = 0; p < N_PORTS; p++) begin
                rsp_valid[p] <= req_valid[p] && !req_write[p];
                rsp_rdata[p] <= rd_word[p];
            end
        end
    end

endmodule

// File: rtl/hsem_bank_chk.sv
module hsem_bank_chk #(
    parameter int N_SEM   = 32,
    parameter int N_CORES = 2,
    parameter int N_PORTS = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [N_PORTS-1:0]             req_valid,
    input logic [N_PORTS-1:0]             req_write,
    input logic [N_PORTS-1:0]             rsp_valid,
    input logic [N_SEM-1:0]               held_vec,
    input logic [N_SEM-1:0]               rel_vec,
    input logic [N_CORES-1:0][N_SEM-1:0]  ier_all,
    input logic [N_CORES-1:0][N_SEM-1:0]  isr_all
);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_p
        AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && !req_write[p]) |=> rsp_valid[p]); // R12
        AST_NO_RSP_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid[p] && !req_write[p]) |=> !rsp_valid[p]); // R12
    end

    for (genvar c = 0; c < N_CORES; c++) begin : g_c
        AST_STATUS_FROM_ENABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            ((isr_all[c] & ~$past(isr_all[c])) & ~$past(rel_vec & ier_all[c])) == '0); // R8
    end

    AST_LOCKS_STABLE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == '0) |=> $stable(held_vec)); // R6

    AST_FREE_ONLY_BY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~held_vec & $past(held_vec)) & ~$past(rel_vec)) == '0); // R7

endmodule

bind hsem_bank hsem_bank_chk #(.N_SEM(N_SEM), .N_CORES(N_CORES), .N_PORTS(N_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .held_vec  (held_vec),
    .rel_vec   (rel_vec),
    .ier_all   (ier_all),
    .isr_all   (isr_all)
);

// File: tb/hsem_bank_tb_top.sv
module hsem_bank_tb_top;

    localparam int NP = 2;
    localparam int NC = 2;
    localparam int NS = 32;
    localparam logic [7:0] A_BULK = 8'd64;
    localparam logic [7:0] A_KEY  = 8'd65;
    localparam logic [7:0] A_IRQ  = 8'd68;
    localparam logic [3:0] CA = 4'd4;
    localparam logic [3:0] CB = 4'd8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NP-1:0]        req_valid = '0;
    logic [NP-1:0]        req_write = '0;
    logic [NP-1:0][7:0]   req_addr  = '0;
    logic [NP-1:0][31:0]  req_wdata = '0;
    logic [NP-1:0][3:0]   req_mid   = '0;
    logic [NP-1:0]        rsp_valid;
    logic [NP-1:0][31:0]  rsp_rdata;
    logic [NC-1:0]        irq_out;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] exp0[$];
    logic [31:0] exp1[$];
    string       tag0[$];
    string       tag1[$];

    hsem_bank #(.N_SEM(NS), .N_CORES(NC), .N_PORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mid(req_mid),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] w(input logic l, input logic [3:0] c, input logic [7:0] p);
        return {l, 19'd0, c, p};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_rsp(input int p);
        logic [31:0] e;
        string t;
        if ((p == 0 && exp0.size() == 0) || (p == 1 && exp1.size() == 0)) begin
            n_run++;
            n_fail++;
            $display("FAIL R12 port %0d: actual response %h expected none", p, rsp_rdata[p]);
            return;
        end
        if (p == 0) begin e = exp0.pop_front(); t = tag0.pop_front(); end
        else        begin e = exp1.pop_front(); t = tag1.pop_front(); end
        chk(rsp_rdata[p], e, t);
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid[0]) check_rsp(0);
            if (rsp_valid[1]) check_rsp(1);
        end
    end

    task automatic put(input int p, input logic wr, input logic [7:0] a,
                       input logic [31:0] d, input logic [3:0] m);
        req_valid[p] = 1'b1;
        req_write[p] = wr;
        req_addr[p]  = a;
        req_wdata[p] = d;
        req_mid[p]   = m;
    endtask

    task automatic expect_rd(input int p, input logic [31:0] e, input string tag);
        if (p == 0) begin exp0.push_back(e); tag0.push_back(tag); end
        else        begin exp1.push_back(e); tag1.push_back(tag); end
    endtask

    task automatic tick();
        @(negedge clk);
        req_valid = '0;
        req_write = '0;
    endtask

    task automatic rd(input int p, input logic [7:0] a, input logic [3:0] m,
                      input logic [31:0] e, input string tag);
        put(p, 1'b0, a, 32'd0, m);
        expect_rd(p, e, tag);
        tick();
    endtask

    task automatic wr(input int p, input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
        put(p, 1'b1, a, d, m);
        tick();
        chk({31'd0, rsp_valid[p]}, 32'd0, "R12 no response to write");
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk({30'd0, irq_out}, 32'd0, "R1 irq after reset");
        rd(0, 8'd3, CA, 32'd0, "R1 sem3 after reset");
        rd(1, A_IRQ + 8'd1, CB, 32'd0, "R1 status0 after reset");
        rd(0, A_KEY, CA, 32'd0, "R1 key after reset");

        wr(0, A_IRQ, (32'd1 << 5) | (32'd1 << 7), CA);
        wr(1, A_IRQ + 8'd4, 32'd1 << 7, CB);
        rd(0, A_IRQ, CA, (32'd1 << 5) | (32'd1 << 7), "R8 enable0 readback");

        // R2 two-step claim
        wr(0, 8'd5, w(1'b1, CA, 8'h21), CA);
        rd(0, 8'd5, CA, w(1'b1, CA, 8'h21), "R2 two-step claim readback");

        // R3 alias claim
        rd(1, 8'd32 + 8'd7, CB, w(1'b1, CB, 8'h00), "R3 alias claim");
        rd(0, 8'd7, CA, w(1'b1, CB, 8'h00), "R3 alias owner stored");

        // R4 held by someone else
        rd(0, 8'd32 + 8'd7, CA, w(1'b1, CB, 8'h00), "R4 alias on held returns owner");
        wr(1, 8'd5, w(1'b1, CB, 8'h01), CB);
        rd(0, 8'd5, CA, w(1'b1, CA, 8'h21), "R4 claim on held ignored");

        // R5 core ID mismatch
        wr(1, 8'd9, w(1'b1, CA, 8'h03), CB);
        rd(0, 8'd9, CA, 32'd0, "R5 mismatched core claim ignored");

        // R6 protected release
        wr(1, 8'd5, w(1'b0, CB, 8'h21), CB);
        rd(0, 8'd5, CA, w(1'b1, CA, 8'h21), "R6 release by other core ignored");
        wr(0, 8'd5, w(1'b0, CA, 8'h22), CA);
        rd(0, 8'd5, CA, w(1'b1, CA, 8'h21), "R6 release with wrong process ignored");
        chk({30'd0, irq_out}, 32'd0, "R6 no interrupt from ignored release");
        wr(0, 8'd5, w(1'b0, CA, 8'h21), CA);
        chk({30'd0, irq_out}, 32'd1, "R8 irq after release of enabled sem");
        rd(0, 8'd5, CA, 32'd0, "R6 matching release frees");
        rd(1, A_IRQ + 8'd1, CB, 32'd1 << 5, "R8 status0 after release");
        rd(1, A_IRQ + 8'd5, CB, 32'd0, "R8 status1 untouched when disabled");

        // R9 clear
        wr(0, A_IRQ + 8'd2, 32'd1 << 5, CA);
        chk({30'd0, irq_out}, 32'd0, "R9 irq low after clear");
        rd(0, A_IRQ + 8'd1, CA, 32'd0, "R9 status0 cleared");

        // R7 keyed bulk release
        rd(1, 8'd32 + 8'd20, CB, w(1'b1, CB, 8'h00), "R3 alias claim sem20");
        rd(1, 8'd32 + 8'd21, CB, w(1'b1, CB, 8'h00), "R3 alias claim sem21");
        rd(0, 8'd32 + 8'd12, CA, w(1'b1, CA, 8'h00), "R3 alias claim sem12");
        wr(0, A_KEY, 32'h0000_BEEF, CA);
        rd(0, A_KEY, CA, 32'h0000_BEEF, "R7 key readback");
        wr(0, A_BULK, {16'h1234, 4'd0, CB, 8'd0}, CA);
        rd(0, 8'd20, CA, w(1'b1, CB, 8'h00), "R7 wrong key releases nothing");
        wr(1, A_BULK, {16'hBEEF, 4'd0, CB, 8'd0}, CB);
        chk({30'd0, irq_out}, 32'd3, "R8 both irqs after bulk release");
        rd(0, 8'd7,  CA, 32'd0, "R7 bulk frees sem7");
        rd(0, 8'd20, CA, 32'd0, "R7 bulk frees sem20");
        rd(0, 8'd21, CA, 32'd0, "R7 bulk frees sem21");
        rd(0, 8'd12, CA, w(1'b1, CA, 8'h00), "R7 other core's sem kept");
        rd(0, A_IRQ + 8'd1, CA, 32'd1 << 7, "R8 status0 after bulk");
        rd(1, A_IRQ + 8'd5, CB, 32'd1 << 7, "R8 status1 after bulk");
        wr(0, A_IRQ + 8'd2, 32'd1 << 7, CA);
        wr(1, A_IRQ + 8'd6, 32'd1 << 7, CB);
        chk({30'd0, irq_out}, 32'd0, "R9 both irqs cleared");

        // R10 same-cycle contention on a free semaphore
        put(0, 1'b0, 8'd32 + 8'd25, 32'd0, CA);
        put(1, 1'b0, 8'd32 + 8'd25, 32'd0, CB);
        expect_rd(0, w(1'b1, CA, 8'h00), "R10 port0 wins contention");
        expect_rd(1, w(1'b1, CA, 8'h00), "R10 port1 sees port0 owner");
        tick();
        rd(1, 8'd25, CB, w(1'b1, CA, 8'h00), "R10 owner after contention");

        // R10 release on port 0 then take on port 1, same cycle
        put(0, 1'b1, 8'd12, w(1'b0, CA, 8'h00), CA);
        put(1, 1'b0, 8'd32 + 8'd12, 32'd0, CB);
        expect_rd(1, w(1'b1, CB, 8'h00), "R10 take after same-cycle release");
        tick();
        rd(0, 8'd12, CA, w(1'b1, CB, 8'h00), "R10 new owner stored");

        // R11 release and clear of the same status bit together
        wr(0, A_IRQ, (32'd1 << 25) | (32'd1 << 5) | (32'd1 << 7), CA);
        put(0, 1'b1, 8'd25, w(1'b0, CA, 8'h00), CA);
        put(1, 1'b1, A_IRQ + 8'd2, 32'd1 << 25, CB);
        tick();
        chk({30'd0, irq_out}, 32'd1, "R11 irq stays high");
        rd(0, A_IRQ + 8'd1, CA, 32'd1 << 25, "R11 set wins over clear");
        rd(1, A_IRQ + 8'd3, CB, 32'd1 << 25, "R8 masked status");
        rd(0, 8'd25, CA, 32'd0, "R6 sem25 freed");

        @(negedge clk);
        @(negedge clk);
        chk(32'(exp0.size() + exp1.size()), 32'd0, "R12 all reads answered");
        finish_run();
    end

endmodule